// File: doc/BRIEF.md
# Compare/Capture Timer

A 16-bit timer for a bus-attached peripheral. A counter advances on ticks from a prescaler that divides the bus clock and never stops. Five compare channels watch for the counter reaching their register value. On a hit a channel raises its status bit and applies a programmed action to its own output pin. Three capture channels copy the counter into a hold register when their synchronised input shows the selected edge. A fifth channel works as either a compare or a capture channel and keeps one register for both roles. Compare channel 1 can also drive any of the five compare pins through a mask and a data value. Software can trigger any compare action at once through a write-only force register.

Register map, as word addresses on a 16-bit port: 0 counter (read only), 1 to 4 compare 1 to 4, 5 shared channel, 6 to 8 capture 1 to 3 (read only), 9 status flags, 10 interrupt enables, 11 control (bits [1:0] divide select, bit 2 shared channel in capture mode, bit 3 overflow interrupt enable), 12 overflow flag (bit 0), 13 pin actions, 14 edge selects, 15 force (write only, reads 0), 16 channel-1 mask, 17 channel-1 data. Writes to read-only addresses are ignored. Reads of unused addresses return 0.

Top module: `cc_timer`

## Requirements
- R1: Control bits [1:0] select a counter step every 1, 4, 8 or 16 bus clocks for codes 0, 1, 2 and 3. A write to control restarts the divide phase, and the counter does not step in that cycle. A code-3 write is followed by exactly 16 clocks at the old value.
- R2: The counter starts at 0 after reset and only ever increments by one. Stepping from 0xFFFF to 0 sets the overflow flag (address 12, bit 0). ovf_irq is the overflow flag ANDed with control bit 3.
- R3: A compare channel sets its status flag on the clock edge at which the counter becomes equal to its register. Flag bits: compare 1 at bit 7, compares 2 to 4 at bits 6 to 4, the shared channel at bit 3, captures 1 to 3 at bits 2 to 0.
- R4: On a compare event, channel k (k = 1..5) applies the action in pin-action bits [2k-1:2k-2] to cmp_pin[k-1]. The codes are 00 none, 01 toggle, 10 drive 0, 11 drive 1.
- R5: For capture channel j (j = 1..4), edge-select bits [2j-1:2j-2] choose the edge: 00 off, 01 rising, 10 falling, 11 both. cap_pin[j-1] passes through two flops. The selected edge copies the counter into the channel's register and sets its flag three clocks after the pin changes.
- R6: When control bit 2 is 0, the shared channel compares against address 5 as compare 5. When it is 1, cap_pin[3] captures into address 5, and status bit 3 reports either role.
- R7: irq[i] is status bit i ANDed with interrupt-enable bit i.
- R8: Writing 1 to a status-flag bit or the overflow-flag bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R9: Writing 1 to force bit k-1 applies compare k's pin action on the next edge and sets no flag.
- R10: A compare-1 event drives every pin whose mask bit is 1 to the matching data bit. On those pins this overrides any other channel's action in the same cycle.
- R11: Compare, enable, control, action, edge, mask and data registers read back what was written. Force reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Register write strobe |
| addr | input | 5 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| cap_pin | input | 4 | Capture inputs; bit 3 feeds the shared channel |
| cmp_pin | output | 5 | Compare outputs for channels 1 to 5 |
| irq | output | 8 | Per-flag interrupt requests |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
A reference counter in the bench tracks the prescaler across all four divide codes. One directed phase check after a code-3 write confirms that the phase restarts rather than continuing. Compare channels are given random targets ahead of the counter with toggle, set and clear actions, which separates flag setting from the action taken on the pin. Capture pins are raised and lowered together under different edge selects, so a channel with the wrong polarity shows up as a latch that should not have happened. Forced events run alone and together with compare 1 to show that the mask overrides another channel's action, and the shared channel runs in both of its roles.

// File: rtl/cc_timer.sv
module cc_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [4:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic [3:0]  cap_pin,
  output logic [4:0]  cmp_pin,
  output logic [7:0]  irq,
  output logic        ovf_irq
);
  localparam logic [4:0] A_CNT = 5'd0, A_CMP5 = 5'd5, A_CAP1 = 5'd6, A_FLG = 5'd9,
    A_IEN = 5'd10, A_CTL = 5'd11, A_OVF = 5'd12, A_ACT = 5'd13, A_EDG = 5'd14,
    A_FRC = 5'd15, A_MSK = 5'd16, A_DAT = 5'd17;

  logic [15:0] cnt, cnt_nx;
  logic [3:0]  psc, psc_last;
  logic [15:0] cmp [5];
  logic [15:0] cap [3];
  logic [7:0]  flg, ien, edg, set_v, clr_v;
  logic [3:0]  ctl, s1, s2, s3, cev;
  logic [9:0]  act;
  logic [4:0]  msk, dat, hit, frc, ev, pin_nx;
  logic        ovf, tick, ctl_wr, mode5;

  assign ctl_wr = we && addr == A_CTL;
  assign mode5  = ctl[2];
  always_comb
    case (ctl[1:0])
      2'd0: psc_last = 4'd0;
      2'd1: psc_last = 4'd3;
      2'd2: psc_last = 4'd7;
      default: psc_last = 4'd15;
    endcase
  assign tick   = psc == psc_last && !ctl_wr;
  assign cnt_nx = cnt + 16'd1;

  always_comb
    for (int k = 0; k < 5; k++)
      hit[k] = tick && cnt_nx == cmp[k] && !(k == 4 && mode5);
  assign frc = (we && addr == A_FRC) ? wdata[4:0] : 5'd0;
  assign ev  = hit | frc;

  always_comb
    for (int j = 0; j < 4; j++)
      cev[j] = (edg[2*j] & s2[j] & ~s3[j]) | (edg[2*j+1] & ~s2[j] & s3[j]);

  assign set_v = {hit[0], hit[1], hit[2], hit[3], hit[4] | (mode5 & cev[3]),
                  cev[0], cev[1], cev[2]};
  assign clr_v = (we && addr == A_FLG) ? wdata[7:0] : 8'd0;

  always_comb
    for (int k = 0; k < 5; k++) begin
      pin_nx[k] = cmp_pin[k];
      if (ev[k])
        case (act[2*k +: 2])
          2'b01: pin_nx[k] = ~cmp_pin[k];
          2'b10: pin_nx[k] = 1'b0;
          2'b11: pin_nx[k] = 1'b1;
          default: ;
        endcase
      if (ev[0] && msk[k]) pin_nx[k] = dat[k];
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      cnt <= '0; psc <= '0; flg <= '0; ien <= '0; ctl <= '0; ovf <= 1'b0;
      act <= '0; edg <= '0; msk <= '0; dat <= '0; cmp_pin <= '0;
      s1 <= '0; s2 <= '0; s3 <= '0;
      for (int k = 0; k < 5; k++) cmp[k] <= '0;
      for (int j = 0; j < 3; j++) cap[j] <= '0;
    end else begin
      s1 <= cap_pin; s2 <= s1; s3 <= s2;
      if (ctl_wr) psc <= '0;
      else if (tick) begin psc <= '0; cnt <= cnt_nx; end
      else psc <= psc + 4'd1;
      ovf <= (ovf & ~(we && addr == A_OVF && wdata[0])) | (tick && cnt == 16'hFFFF);
      flg <= (flg & ~clr_v) | set_v;
      cmp_pin <= pin_nx;
      for (int j = 0; j < 3; j++) if (cev[j]) cap[j] <= cnt;
      for (int k = 0; k < 4; k++) if (we && addr == 5'(k + 1)) cmp[k] <= wdata;
      if (mode5 && cev[3]) cmp[4] <= cnt;
      else if (we && addr == A_CMP5) cmp[4] <= wdata;
      if (we)
        case (addr)
          A_IEN: ien <= wdata[7:0];
          A_CTL: ctl <= wdata[3:0];
          A_ACT: act <= wdata[9:0];
          A_EDG: edg <= wdata[7:0];
          A_MSK: msk <= wdata[4:0];
          A_DAT: dat <= wdata[4:0];
          default: ;
        endcase
    end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CNT: rdata = cnt;
      5'd1, 5'd2, 5'd3, 5'd4, A_CMP5: rdata = cmp[addr - 5'd1];
      A_CAP1, 5'd7, 5'd8: rdata = cap[addr - A_CAP1];
      A_FLG: rdata = {8'd0, flg};
      A_IEN: rdata = {8'd0, ien};
      A_CTL: rdata = {12'd0, ctl};
      A_OVF: rdata = {15'd0, ovf};
      A_ACT: rdata = {6'd0, act};
      A_EDG: rdata = {8'd0, edg};
      A_MSK: rdata = {11'd0, msk};
      A_DAT: rdata = {11'd0, dat};
      default: rdata = '0;
    endcase
  end

  assign irq     = flg & ien;
  assign ovf_irq = ovf & ctl[3];

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != $past(cnt) |-> cnt == $past(cnt) + 16'd1);
  // R2
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == 16'hFFFF && cnt == 16'h0) |-> ovf);
  // R5
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap[0] != $past(cap[0]) |-> flg[2]);
  // R9
  force_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frc != 5'd0 && !tick) |-> (flg[7:4] & ~$past(flg[7:4])) == 4'b0);
  // R10
  mask_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev[0] && msk[1]) |-> cmp_pin[1] == $past(dat[1]));
endmodule

// File: tb/cc_timer_test.sv
`timescale 1ns/1ps
module cc_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [3:0] cap_pin = '0;
  logic [4:0] cmp_pin;
  logic [7:0] irq;
  logic ovf_irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  cc_timer uut (.clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_pin(cap_pin), .cmp_pin(cmp_pin), .irq(irq), .ovf_irq(ovf_irq));

  always #2.5 clk = ~clk;

  // reference counter built from R1/R2
  logic [15:0] m_cnt;
  logic [3:0]  m_psc;
  logic [1:0]  m_sel;
  function automatic logic [3:0] last_of(input logic [1:0] s);
    return s == 2'd0 ? 4'd0 : s == 2'd1 ? 4'd3 : s == 2'd2 ? 4'd7 : 4'd15;
  endfunction
  always @(posedge clk)
    if (!rst_n) begin m_cnt <= 0; m_psc <= 0; m_sel <= 0; end
    else if (we && addr == 5'd11) begin m_psc <= 0; m_sel <= wdata[1:0]; end
    else if (m_psc == last_of(m_sel)) begin m_psc <= 0; m_cnt <= m_cnt + 16'd1; end
    else m_psc <= m_psc + 4'd1;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    addr = a; #0.5; v = rdata;
  endtask
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [15:0] v, b, e1, e2, c0;
    logic p;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    rd(5'd9, v); chk("R3 reset flags", v, 16'h0);
    rd(5'd6, v); chk("R5 reset capture", v, 16'h0);
    chk("R4 reset pins", {11'd0, cmp_pin}, 16'h0);
    chk("R7 reset irq", {8'd0, irq}, 16'h0);
    rd(5'd0, v); chk("R1 counter follows model", v, m_cnt);

    // R11 readback
    b = 16'($urandom);
    wr(5'd2, b); rd(5'd2, v); chk("R11 compare2 readback", v, b);
    wr(5'd10, 16'h00A5); rd(5'd10, v); chk("R11 enable readback", v, 16'h00A5);
    wr(5'd15, 16'h001F); rd(5'd15, v); chk("R11 force reads zero", v, 16'h0);
    wr(5'd10, 16'h0); wr(5'd9, 16'h00FF);

    // R1 prescaler
    for (int s = 1; s <= 4; s++) begin
      wr(5'd11, 16'(s % 4));
      cyc(37 + s);
      rd(5'd0, v); chk("R1 divide code", v, m_cnt);
    end
    wr(5'd11, 16'd3); rd(5'd0, c0);
    cyc(15); rd(5'd0, v); chk("R1 phase restart hold", v, c0);
    cyc(1);  rd(5'd0, v); chk("R1 phase restart step", v, c0 + 16'd1);
    wr(5'd11, 16'd0);

    // R3/R4 directed: ch2 toggle, ch3 set, ch4 clear
    wr(5'd13, 16'h00B4); wr(5'd9, 16'h00FF);
    b = m_cnt;
    wr(5'd2, b + 16'd20); wr(5'd3, b + 16'd22); wr(5'd4, b + 16'd24);
    cyc(30);
    rd(5'd9, v); chk("R3 flags compares 2-4", v, 16'h0070);
    chk("R4 pin actions", {11'd0, cmp_pin}, 16'h0006);

    // R8
    wr(5'd9, 16'h0000); rd(5'd9, v); chk("R8 write zero keeps", v, 16'h0070);
    wr(5'd9, 16'h0040); rd(5'd9, v); chk("R8 write one clears", v, 16'h0030);

    // R7
    wr(5'd10, 16'h0060); chk("R7 irq gating a", {8'd0, irq}, 16'h0020);
    wr(5'd10, 16'h0010); chk("R7 irq gating b", {8'd0, irq}, 16'h0010);
    wr(5'd10, 16'h0); wr(5'd9, 16'h00FF);

    // R9 force
    wr(5'd13, 16'h00C0);
    wr(5'd15, 16'h0008);
    chk("R9 force sets pin", {11'd0, cmp_pin}, 16'h000E);
    wr(5'd15, 16'h0004);
    chk("R9 force with no action", {11'd0, cmp_pin}, 16'h000E);
    rd(5'd9, v); chk("R9 force sets no flag", v, 16'h0);

    // R10 mask/data override
    wr(5'd16, 16'h0012); wr(5'd17, 16'h0012); wr(5'd13, 16'h0004);
    wr(5'd15, 16'h0003);
    chk("R10 mask wins over toggle", {11'd0, cmp_pin}, 16'h001E);
    wr(5'd15, 16'h0002);
    chk("R10 other channel alone", {11'd0, cmp_pin}, 16'h001C);
    wr(5'd16, 16'h0);

    // R5 capture: cap1 rising, cap2 falling, cap3 both
    wr(5'd14, 16'h0039); wr(5'd9, 16'h00FF);
    cap_pin = 4'b0111;
    @(posedge clk); @(posedge clk); #0.5 e1 = m_cnt;
    cyc(3);
    rd(5'd6, v); chk("R5 rising capture", v, e1);
    rd(5'd7, v); chk("R5 falling select ignores rise", v, 16'h0);
    rd(5'd8, v); chk("R5 both edges rise", v, e1);
    rd(5'd9, v); chk("R5 flags after rise", v, 16'h0005);
    wr(5'd9, 16'h00FF);
    cap_pin = 4'b0000;
    @(posedge clk); @(posedge clk); #0.5 e2 = m_cnt;
    cyc(3);
    rd(5'd6, v); chk("R5 rising select ignores fall", v, e1);
    rd(5'd7, v); chk("R5 falling capture", v, e2);
    rd(5'd8, v); chk("R5 both edges fall", v, e2);
    rd(5'd9, v); chk("R5 flags after fall", v, 16'h0003);
    wr(5'd9, 16'h00FF);

    // R6 shared channel
    wr(5'd13, 16'h0200);
    b = m_cnt; wr(5'd5, b + 16'd15);
    cyc(20);
    rd(5'd9, v); chk("R6 compare5 flag", v, 16'h0008);
    chk("R6 compare5 clears pin", {11'd0, cmp_pin}, 16'h000C);
    wr(5'd9, 16'h00FF);
    wr(5'd11, 16'h0004); wr(5'd14, 16'h0040);
    cap_pin = 4'b1000;
    @(posedge clk); @(posedge clk); #0.5 e1 = m_cnt;
    cyc(3);
    rd(5'd5, v); chk("R6 capture into shared register", v, e1);
    rd(5'd9, v); chk("R6 capture flag", v, 16'h0008);
    cap_pin = 4'b0000;
    wr(5'd11, 16'h0); wr(5'd9, 16'h00FF);

    // R3/R4 random targets with toggle
    wr(5'd13, 16'h0054);
    for (int i = 0; i < 6; i++) begin
      int ch;
      int off;
      ch = 2 + int'($urandom % 3);
      off = 4 + int'($urandom % 60);
      p = cmp_pin[ch-1];
      wr(5'(ch), m_cnt + 16'(off));
      cyc(off + 3);
      rd(5'd9, v); chk("R3 random compare flag", {15'd0, v[8-ch]}, 16'h1);
      chk("R4 random toggle", {15'd0, cmp_pin[ch-1]}, {15'd0, ~p});
      wr(5'd9, 16'h00FF);
    end

    // R2 overflow
    wr(5'd11, 16'h0008);
    while (m_cnt != 16'hFFFF) @(negedge clk);
    rd(5'd12, v); chk("R2 no overflow before wrap", v, 16'h0);
    @(negedge clk);
    rd(5'd0, v); chk("R2 counter wraps", v, 16'h0);
    rd(5'd12, v); chk("R2 overflow flag", v, 16'h1);
    chk("R2 overflow irq", {15'd0, ovf_irq}, 16'h1);
    wr(5'd12, 16'h1); rd(5'd12, v); chk("R8 overflow clear", v, 16'h0);

    finish_up();
  end
endmodule